// File: doc/BRIEF.md
# LCL Inverter Current State-Feedback Regulator

This block closes the current loop of a voltage-source inverter that is tied to a source through an inductor-capacitor-inductor filter. Once per control period (20 µs in the intended system) a sample strobe presents four signed fixed-point values: the measured source-side current, the measured bridge-side current and the wanted value of each. The block subtracts each measurement from its wanted value and weights the two differences with a constant gain row. It adds the weighted terms into one control effort and clamps it to the output width.

The gain row comes from an optimal quadratic design over the three filter states. The weight on the capacitor voltage was small enough to drop, so that voltage is not measured and does not enter the law. The source-side current gets the large weight, because it is the quantity that has to track a mains-frequency reference. Each gain is a signed Q2.14 constant.

The clamped effort drives a comparator with a band set at run time. The comparator produces the on/off command for one bridge leg. The command turns on above the band, turns off below its negative, and keeps its state inside the band, so the leg does not chatter on a noisy effort.

Top module: `fbk_current_ctl`

## Requirements
- R1: After reset `effort` is 0, `legOn` is 0 and `effortValid` is 0.
- R2: For a sample taken at rising edge k, `effort` after edge k+1 equals floor((KG·(gridRef−gridCur) + KI·(invRef−invCur)) / 2^14), with default KG = 10138 (0.6188 in Q2.14) and KI = 1522 (0.0929 in Q2.14). The sum is formed at full width and the floor is an arithmetic right shift.
- R3: A result above 32767 gives `effort` = 32767, and one below −32768 gives −32768 (16-bit two's-complement output).
- R4: `effort` keeps its value in every cycle that does not load a new sample result.
- R5: `legOn` becomes 1 at edge k+2 when the effort loaded at edge k+1 is greater than `hystBand`.
- R6: `legOn` becomes 0 at edge k+2 when that effort is less than −`hystBand`.
- R7: When that effort lies within [−`hystBand`, +`hystBand`], and in cycles with no new result, `legOn` keeps its value.
- R8: `effortValid` is 1 for exactly the cycle after edge k+1 for each sample strobe accepted at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe: the four currents below are valid |
| gridCur | input | 16 | Measured source-side current, signed |
| invCur | input | 16 | Measured bridge-side current, signed |
| gridRef | input | 16 | Wanted source-side current, signed |
| invRef | input | 16 | Wanted bridge-side current, signed |
| hystBand | input | 15 | Comparator half-band, unsigned |
| effort | output | 16 | Clamped control effort, signed |
| effortValid | output | 1 | One-cycle flag: new effort loaded |
| legOn | output | 1 | Leg switching command |

## Verification
The hardest case to reach from the ports is the leg command holding its state across many in-band efforts after it has been driven to one side. A naive comparator would toggle or fall back to a default, and random stimulus rarely stays inside the band long enough to show it. The bench first drives a large positive error to set the leg. It then applies a series of small errors whose efforts all fall inside a wide band, and checks after each one that the leg has not moved. The same pattern is repeated after clearing the leg. Full-scale opposite-sign inputs push the full-width sum past both clamp limits.

// File: rtl/fbk_ctl_pkg.sv
package fbk_ctl_pkg;
  typedef struct packed {
    logic loadErr;
    logic loadEffort;
    logic updateLeg;
  } strobe_t;
endpackage

// File: rtl/fbk_ctl_seq.sv
module fbk_ctl_seq
  import fbk_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleValid,
  output strobe_t strobes,
  output logic    resultValid
);
  logic stageA;
  logic stageB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageA <= 1'b0;
      stageB <= 1'b0;
    end else begin
      stageA <= sampleValid;
      stageB <= stageA;
    end
  end

  always_comb begin
    strobes.loadErr    = sampleValid;
    strobes.loadEffort = stageA;
    strobes.updateLeg  = stageB;
  end

  assign resultValid = stageB;
endmodule

// File: rtl/fbk_ctl_dp.sv
module fbk_ctl_dp
  import fbk_ctl_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int OUT_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter logic signed [GAIN_W-1:0] K_GRID = 16'sd10138,
  parameter logic signed [GAIN_W-1:0] K_INV  = 16'sd1522
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobes,
  input  logic signed [DATA_W-1:0] gridCur,
  input  logic signed [DATA_W-1:0] invCur,
  input  logic signed [DATA_W-1:0] gridRef,
  input  logic signed [DATA_W-1:0] invRef,
  input  logic        [OUT_W-2:0]  hystBand,
  output logic signed [OUT_W-1:0]  effort,
  output logic                     legOn
);
  localparam int ERR_W = DATA_W + 1;
  localparam int SUM_W = ERR_W + GAIN_W + 1;
  localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] OUT_MIN = -OUT_MAX - SUM_W'(1);

  logic signed [ERR_W-1:0] errGrid, errInv;
  logic signed [SUM_W-1:0] prodGrid, prodInv, sumFull, scaled;
  logic signed [OUT_W-1:0] clamped;
  logic signed [OUT_W:0]   effortExt, bandPos, bandNeg;

  // error stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errGrid <= '0;
      errInv  <= '0;
    end else if (strobes.loadErr) begin
      errGrid <= ERR_W'(gridRef) - ERR_W'(gridCur);
      errInv  <= ERR_W'(invRef) - ERR_W'(invCur);
    end
  end

  // weighting, sum, scale, clamp
  always_comb begin
    prodGrid = SUM_W'(errGrid) * SUM_W'(K_GRID);
    prodInv  = SUM_W'(errInv) * SUM_W'(K_INV);
    sumFull  = prodGrid + prodInv;
    scaled   = sumFull >>> GAIN_FRAC;
    if (scaled > OUT_MAX)      clamped = OUT_MAX[OUT_W-1:0];
    else if (scaled < OUT_MIN) clamped = OUT_MIN[OUT_W-1:0];
    else                       clamped = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      effort <= '0;
    else if (strobes.loadEffort)    effort <= clamped;
  end

  // hysteresis comparator
  always_comb begin
    effortExt = (OUT_W+1)'(effort);
    bandPos   = $signed({2'b00, hystBand});
    bandNeg   = -bandPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) legOn <= 1'b0;
    else if (strobes.updateLeg) begin
      if (effortExt > bandPos)      legOn <= 1'b1;
      else if (effortExt < bandNeg) legOn <= 1'b0;
    end
  end

  a_r4_effort_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEffort |=> $stable(effort));
  a_r5_leg_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.updateLeg && effortExt > bandPos) |=> legOn);
  a_r6_leg_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.updateLeg && effortExt < bandNeg) |=> !legOn);
  a_r7_no_chatter: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.updateLeg || (effortExt <= bandPos && effortExt >= bandNeg)) |=> $stable(legOn));
endmodule

// File: rtl/fbk_current_ctl.sv
module fbk_current_ctl
  import fbk_ctl_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int OUT_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter logic signed [GAIN_W-1:0] K_GRID = 16'sd10138,
  parameter logic signed [GAIN_W-1:0] K_INV  = 16'sd1522
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] gridCur,
  input  logic signed [DATA_W-1:0] invCur,
  input  logic signed [DATA_W-1:0] gridRef,
  input  logic signed [DATA_W-1:0] invRef,
  input  logic        [OUT_W-2:0]  hystBand,
  output logic signed [OUT_W-1:0]  effort,
  output logic                     effortValid,
  output logic                     legOn
);
  strobe_t strobes;

  fbk_ctl_seq uSeq (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .strobes(strobes), .resultValid(effortValid)
  );

  fbk_ctl_dp #(
    .DATA_W(DATA_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
    .K_GRID(K_GRID), .K_INV(K_INV)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .gridCur(gridCur), .invCur(invCur), .gridRef(gridRef), .invRef(invRef),
    .hystBand(hystBand), .effort(effort), .legOn(legOn)
  );

  logic validD1, validD2;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validD1 <= 1'b0;
      validD2 <= 1'b0;
    end else begin
      validD1 <= sampleValid;
      validD2 <= validD1;
    end
  end

  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    effortValid == validD2);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(!rstN) |-> (effort == '0 && !legOn && !effortValid));
endmodule

// File: tb/tb_fbk_current_ctl.sv
module tb_fbk_current_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] gridCur = '0, invCur = '0, gridRef = '0, invRef = '0;
  logic [14:0] hystBand = '0;
  logic signed [15:0] effort;
  logic effortValid, legOn;

  int total = 0;
  int bad = 0;
  int expQ[$];
  bit expLeg = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fbk_current_ctl dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .gridCur(gridCur), .invCur(invCur), .gridRef(gridRef), .invRef(invRef),
    .hystBand(hystBand), .effort(effort), .effortValid(effortValid), .legOn(legOn)
  );

  function automatic int modelEffort(int gr, int g, int ir, int i);
    longint s;
    s = longint'(10138) * (gr - g) + longint'(1522) * (ir - i);
    s = s >>> 14;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int gr, int g, int ir, int i);
    @(negedge clk);
    gridRef = 16'(gr); gridCur = 16'(g); invRef = 16'(ir); invCur = 16'(i);
    sampleValid = 1'b1;
    expQ.push_back(modelEffort(gr, g, ir, i));
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && effortValid) begin
        int e, band, held;
        band = int'(hystBand);
        if (expQ.size() == 0) begin
          check("R8 unexpected effortValid", 1, 0);
        end else begin
          e = expQ.pop_front();
          check("R2/R3 effort", int'(effort), e);
          if (e > band) expLeg = 1'b1;
          else if (e < -band) expLeg = 1'b0;
          held = int'(effort);
          @(negedge clk);
          check("R8 effortValid single cycle", int'(effortValid), 0);
          check("R5/R6/R7 legOn", int'(legOn), int'(expLeg));
          @(negedge clk);
          check("R4 effort held", int'(effort), held);
          check("R7 legOn held", int'(legOn), int'(expLeg));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 effort reset", int'(effort), 0);
    check("R1 legOn reset", int'(legOn), 0);
    check("R1 effortValid reset", int'(effortValid), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 effort after release", int'(effort), 0);

    hystBand = 15'd100;
    // R2 directed
    drive(1000, 0, 0, 0);
    drive(0, 0, 2000, 0);
    drive(-500, 700, 300, -300);
    drive(0, 1, 0, 0);   // tiny negative: floor rounding
    // R3 clamps
    drive(32767, -32768, 32767, -32768);
    drive(-32768, 32767, -32768, 32767);
    // R5 set, then R7 in-band chatter check
    hystBand = 15'd2000;
    drive(20000, 0, 0, 0);
    for (int n = 0; n < 8; n++) drive((n % 2) ? 3000 : -3000, 0, 0, 0);
    // R6 clear, then in-band again
    drive(-20000, 0, 0, 0);
    for (int n = 0; n < 8; n++) drive((n % 2) ? 3200 : -3200, 0, 0, 0);
    // band edge: effort exactly equal to band holds (R7)
    hystBand = 15'd618;
    drive(1000, 0, 0, 0);   // effort 618 -> hold at 0
    drive(1001, 0, 0, 0);   // effort 619 -> set (R5)
    // random R2
    for (int n = 0; n < 300; n++) begin
      hystBand = 15'($urandom_range(0, 4000));
      drive($signed(16'($urandom)), $signed(16'($urandom)),
            $signed(16'($urandom)), $signed(16'($urandom)));
    end
    repeat (6) @(negedge clk);
    check("R8 all results seen", expQ.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule